// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register Block

This block is the software-facing register set of one bus-mastering disk DMA channel. A host reaches three registers over a simple single-cycle register bus: a byte-wide command register, a byte-wide status register and a 32-bit descriptor table pointer. The command register drives a start level and a direction level to the transfer engine. The pointer output tells the engine where its descriptor list begins.

The status register mixes several kinds of bit. Some bits are live views of the engine. Some are sticky event flags that software clears by writing one. Two are plain storage bits that software uses to mark each of the two drives as DMA-capable.

The usual driver sequence has four steps. Software loads the table pointer and picks the direction. It clears stale error and interrupt flags by writing ones to them. It then sets the start bit. At completion it clears start and inspects the flags.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, dma_start, dma_to_mem and tbl_ptr are 0, and all three registers read as 0 while the engine inputs are low.
- R2: A write to the command register (addr 0) sets dma_start to wdata bit 0 from the next cycle. Writing 1 starts the transfer and writing 0 stops it.
- R3: Command bit 3 is stored and drives dma_to_mem. A value of 1 means device-to-memory and 0 means memory-to-device. Command bits other than 0 and 3 read as 0.
- R4: Status bit 0 (addr 1) reads the current level of eng_active. Writes to that bit have no effect.
- R5: A 0-to-1 edge on err_evt sets status bit 1, and a 0-to-1 edge on irq_evt sets status bit 2. An input held high does not set its bit again after the bit has been cleared.
- R6: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged.
- R7: When an event edge and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R8: Status bits 5 and 6 are the drive-0 and drive-1 DMA-capable flags. Each holds the last value written to it.
- R9: Status bits 3 and 4 both read 1 while busy_hold is high and 0 otherwise, so the byte shows 0x18 in that condition. They are not writable. Status bit 7 reads 0.
- R10: A write to addr 2 loads the table pointer from wdata with bits 1:0 forced to 0. It reads back the same way and drives tbl_ptr.
- R11: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| wdata | input | 32 | Write data; byte registers use bits 7:0 |
| rdata | output | 32 | Read data for addr, combinational |
| eng_active | input | 1 | Engine reports a transfer in progress |
| err_evt | input | 1 | Error event level; rising edge sets the flag |
| irq_evt | input | 1 | Interrupt event level; rising edge sets the flag |
| busy_hold | input | 1 | Busy condition shown in status bits 3 and 4 |
| dma_start | output | 1 | Start level to the engine |
| dma_to_mem | output | 1 | Direction: 1 device-to-memory |
| tbl_ptr | output | 32 | Descriptor table base, 4-byte aligned |

## Verification
The bench targets the same-cycle collision between an event edge and a write-one clear. A design that gives the clear priority would lose an interrupt that arrives just as software acknowledges the previous one. It also holds an event input high across a clear. Level-triggered flag logic would set the flag again at once and trap the driver in its handler. Writes of zero to the sticky bits, writes to the read-only active and busy bits, and unaligned pointer writes are issued as well. Each of these catches a register that stores bits it should not store, or that wipes flags on a plain status update.

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int PTR_W   = 32,
  parameter int ALIGN_B = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             eng_active,
  input  logic             err_evt,
  input  logic             irq_evt,
  input  logic             busy_hold,
  output logic             dma_start,
  output logic             dma_to_mem,
  output logic [PTR_W-1:0] tbl_ptr
);
  localparam logic [1:0] A_CMD = 2'd0;
  localparam logic [1:0] A_STS = 2'd1;
  localparam logic [1:0] A_PTR = 2'd2;

  logic       err_q, irq_q, err_evt_q, irq_evt_q;
  logic [1:0] cap_q;
  logic       err_rise, irq_rise, wr_cmd, wr_sts, wr_ptr;

  assign err_rise = err_evt & ~err_evt_q;
  assign irq_rise = irq_evt & ~irq_evt_q;
  assign wr_cmd   = we && addr == A_CMD;
  assign wr_sts   = we && addr == A_STS;
  assign wr_ptr   = we && addr == A_PTR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_start  <= 1'b0;
      dma_to_mem <= 1'b0;
      tbl_ptr    <= '0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      cap_q      <= 2'b00;
      err_evt_q  <= 1'b0;
      irq_evt_q  <= 1'b0;
    end else begin
      err_evt_q <= err_evt;
      irq_evt_q <= irq_evt;
      if (wr_cmd) begin
        dma_start  <= wdata[0];
        dma_to_mem <= wdata[3];
      end
      if (wr_sts) cap_q <= wdata[6:5];
      if (wr_ptr) tbl_ptr <= {wdata[PTR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
      if (err_rise)                err_q <= 1'b1;
      else if (wr_sts && wdata[1]) err_q <= 1'b0;
      if (irq_rise)                irq_q <= 1'b1;
      else if (wr_sts && wdata[2]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CMD: rdata[7:0] = {4'b0000, dma_to_mem, 2'b00, dma_start};
      A_STS: rdata[7:0] = {1'b0, cap_q, busy_hold, busy_hold, irq_q, err_q, eng_active};
      A_PTR: rdata[PTR_W-1:0] = tbl_ptr;
      default: rdata = '0;
    endcase
  end

  // R2
  start_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> dma_start == $past(wdata[0]));
  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !err_evt_q) |=> err_q);
  // R7
  irq_set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rise && wr_sts && wdata[2]) |=> irq_q);
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[1] && !err_rise) |=> !err_q);
  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> $stable(cap_q));
  // R10
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr |=> tbl_ptr[PTR_W-1:ALIGN_B] == $past(wdata[PTR_W-1:ALIGN_B]));
endmodule

// File: tb/bmdma_regs_tb_top.sv
`timescale 1ns/1ps
module bmdma_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic we = 0, act = 0, errv = 0, irqv = 0, busy = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, ptr;
  logic dstart, dmem;
  int n_chk = 0, n_fail = 0;

  logic m_start = 0, m_dir = 0, m_err = 0, m_irq = 0, m_ep = 0, m_ip = 0;
  logic [1:0] m_cap = 0;
  logic [31:0] m_ptr = 0;

  always #2 clk = ~clk;

  bmdma_regs dut_i (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .eng_active(act), .err_evt(errv), .irq_evt(irqv), .busy_hold(busy),
    .dma_start(dstart), .dma_to_mem(dmem), .tbl_ptr(ptr));

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {24'd0, 4'd0, m_dir, 2'd0, m_start};
      2'd1: return {24'd0, 1'b0, m_cap, busy, busy, m_irq, m_err, act};
      2'd2: return m_ptr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    logic er, ir;
    @(posedge clk);
    if (rst_n) begin
      er = errv & ~m_ep; ir = irqv & ~m_ip;
      m_ep = errv; m_ip = irqv;
      if (we && addr == 0) begin m_start = wdata[0]; m_dir = wdata[3]; end
      if (we && addr == 1) begin
        if (wdata[1]) m_err = 0;
        if (wdata[2]) m_irq = 0;
        m_cap = wdata[6:5];
      end
      if (we && addr == 2) m_ptr = {wdata[31:2], 2'b00};
      if (er) m_err = 1;
      if (ir) m_irq = 1;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d; cyc(); we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a);
    addr = a; #0.1; chk(tag, rdata, exp_read(a));
  endtask

  task automatic out_chk(input string tag);
    chk(tag, {dstart, dmem}, {m_start, m_dir});
    chk(tag, ptr, m_ptr);
  endtask

  initial begin
    #400000; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    out_chk("R1 outputs");
    for (int a = 0; a < 4; a++) rd_chk("R1 read", 2'(a));
    // R2 start then stop
    wr(0, 32'h1); rd_chk("R2 start", 0); out_chk("R2 start out");
    wr(0, 32'h0); rd_chk("R2 stop", 0); out_chk("R2 stop out");
    // R3 direction, other bits zero
    wr(0, 32'hFF); rd_chk("R3 dir all ones", 0); out_chk("R3 out");
    wr(0, 32'hF7); rd_chk("R3 dir zero", 0);
    // R4 active mirrors input, not writable
    act = 1; rd_chk("R4 active high", 1);
    wr(1, 32'h01); act = 0; rd_chk("R4 write ignored", 1);
    // R5 edge sets, held level does not re-set
    errv = 1; irqv = 1; cyc(); rd_chk("R5 set", 1);
    wr(1, 32'h06); rd_chk("R5 held no reset", 1);
    cyc(); rd_chk("R5 still clear", 1);
    errv = 0; irqv = 0; cyc();
    // R6 write 0 keeps, write 1 clears
    errv = 1; cyc(); errv = 0;
    irqv = 1; cyc(); irqv = 0;
    wr(1, 32'h00); rd_chk("R6 zero keeps", 1);
    wr(1, 32'h02); rd_chk("R6 clear err only", 1);
    wr(1, 32'h04); rd_chk("R6 clear irq", 1);
    // R7 set beats clear
    irqv = 1; errv = 1; wr(1, 32'h06); irqv = 0; errv = 0;
    rd_chk("R7 set wins", 1);
    wr(1, 32'h06); rd_chk("R7 then cleared", 1);
    // R8 capable bits
    wr(1, 32'h20); rd_chk("R8 drive0", 1);
    wr(1, 32'h40); rd_chk("R8 drive1", 1);
    wr(1, 32'h60); rd_chk("R8 both", 1);
    // R9 busy bits and bit 7
    busy = 1; wr(1, 32'hFF); rd_chk("R9 busy 0x18", 1);
    busy = 0; wr(1, 32'h98); rd_chk("R9 not writable", 1);
    // R10 pointer
    wr(2, 32'hDEAD_BEEF); rd_chk("R10 aligned", 2); out_chk("R10 out");
    wr(2, 32'h0000_1002); rd_chk("R10 low bits", 2);
    // R11 addr 3
    wr(3, 32'hFFFF_FFFF); rd_chk("R11 read zero", 3);
    for (int a = 0; a < 3; a++) rd_chk("R11 no effect", 2'(a));
    out_chk("R11 out");

    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      we = 1'($urandom); addr = 2'($urandom); wdata = $urandom;
      act = 1'($urandom); busy = 1'($urandom);
      errv = ($urandom % 4 == 0) ? ~errv : errv;
      irqv = ($urandom % 4 == 0) ? ~irqv : irqv;
      cyc();
      we = 0;
      addr = 2'($urandom); #0.1;
      chk("random R2/R5/R6/R7/R10 read", rdata, exp_read(addr));
      out_chk("random outputs");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule